// File: doc/BRIEF.md
# Capture and Compare Timer

A free-running 16-bit counter advances once per prescaled tick and serves three event sources. The first is an input-capture channel, which stores the counter value when a chosen edge appears on an external input. The second is an output-compare channel, which drives a programmed level onto an output pin when the counter reaches a stored value. The third is overflow detection when the counter wraps. Each source sets a flag in a status register. An interrupt line is raised whenever a flag is set and its enable is also set.

Software reaches the block through a small synchronous byte bus with eight register addresses. A control byte holds the three interrupt enables, the capture edge polarity and the compare output level. Reset clears the enables and the output level. Reset leaves the capture polarity as it was, so a warm reset keeps the edge choice made before it.

Top module: `cct_timer`

## Requirements
- R1: The control register at address 0 has capture enable at bit 7, compare enable at bit 6, overflow enable at bit 5, edge select at bit 1 and output level at bit 0. Bits 4 to 2 always read 0, whatever value was written to them.
- R2: Reset clears the three enables and the output level. The edge-select bit keeps the value it held before reset.
- R3: The counter, read as high byte at address 2 and low byte at address 3, starts at 0 after reset. It advances by one every PRESCALE clocks and wraps from 0xFFFF to 0x0000. The wrap sets the overflow flag, which is status bit 5.
- R4: With edge select at 1, a rising edge on `cap_in` stores the counter into the capture register (high byte at address 4, low byte at address 5) and sets the capture flag, status bit 7. The stored value is the counter as it stands two clocks after the input changes.
- R5: With edge select at 0, a falling edge captures instead. An edge of the other polarity changes neither the capture register nor the flag.
- R6: When the counter takes the value held in the compare register (high byte at address 6, low byte at address 7, reset value 0xFFFF), `cmp_out` takes the output-level bit on the following clock. It also sets the compare flag, status bit 6. The pin then holds its value until the next match.
- R7: Writing 1 to a bit of the status register at address 1 clears that flag. Writing 0 has no effect.
- R8: `irq` is high exactly when some status flag is set and its enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| bus_sel | input | 1 | bus access strobe |
| bus_wr | input | 1 | 1 = write, sampled with bus_sel |
| bus_addr | input | 3 | register address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data for bus_addr, combinational |
| cap_in | input | 1 | asynchronous capture input |
| cmp_out | output | 1 | compare output pin |
| irq | output | 1 | combined interrupt request |

## Verification
The hardest state to reach is the counter wrap, because it needs 65536 ticks. The bench uses a prescale of one and waits for the wrap while keeping its own cycle count since reset. That count also gives the exact expected value for every capture and compare. Edge-select retention needs a second reset applied mid-run after the bit has been written to 1.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] RA_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] RA_STAT   = 3'd1;
  localparam logic [ADDR_W-1:0] RA_CNT_H  = 3'd2;
  localparam logic [ADDR_W-1:0] RA_CNT_L  = 3'd3;
  localparam logic [ADDR_W-1:0] RA_CAP_H  = 3'd4;
  localparam logic [ADDR_W-1:0] RA_CAP_L  = 3'd5;
  localparam logic [ADDR_W-1:0] RA_CMP_H  = 3'd6;
  localparam logic [ADDR_W-1:0] RA_CMP_L  = 3'd7;

  localparam int B_CAP = 7;
  localparam int B_CMP = 6;
  localparam int B_OVF = 5;
  localparam int B_EDG = 1;
  localparam int B_LVL = 0;

  typedef struct packed {
    logic cap_ie;
    logic cmp_ie;
    logic ovf_ie;
    logic edge_rise;
    logic out_lvl;
  } ctrl_t;

  typedef struct packed {
    logic cap;
    logic cmp;
    logic ovf;
  } flags_t;

  function automatic logic [BYTE_W-1:0] ctrl_to_byte(ctrl_t c);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[B_CAP] = c.cap_ie;
    b[B_CMP] = c.cmp_ie;
    b[B_OVF] = c.ovf_ie;
    b[B_EDG] = c.edge_rise;
    b[B_LVL] = c.out_lvl;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] flags_to_byte(flags_t f);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[B_CAP] = f.cap;
    b[B_CMP] = f.cmp;
    b[B_OVF] = f.ovf;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] pick_byte(logic [CNT_W-1:0] v, logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] count_next(logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pc <= '0;
        else if (pc == LAST) pc <= '0;
        else                 pc <= pc + 1'b1;
      end
      assign tick = (pc == LAST);
    end
  endgenerate
endmodule

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap_evt,
  output logic             cnt_moved
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assign wrap_evt = tick && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_moved <= 1'b0;
    end else begin
      cnt_moved <= tick;
      if (tick) cnt_q <= count_next(cnt_q);
    end
  end

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == TOP) |=> (cnt_q == '0));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
endmodule

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic rise_sel,
  output logic hit_rise,
  output logic hit_fall,
  output logic hit
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign hit_rise = sh[STAGES-1] & ~sh[STAGES];
  assign hit_fall = ~sh[STAGES-1] & sh[STAGES];
  assign hit      = rise_sel ? hit_rise : hit_fall;

  a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rise |=> !hit_rise);
  a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fall |=> !hit_fall);
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              cap_in,
  output logic              cmp_out,
  output logic              irq
);
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic             ovf_evt;
  logic             cnt_moved;
  logic             cap_evt;
  logic             cap_rise;
  logic             cap_fall;
  logic             cmp_hit;

  ctrl_t            ctrl;
  logic             edge_q = 1'b0;
  flags_t           flags;
  logic [CNT_W-1:0] cap_q;
  logic [CNT_W-1:0] cmp_q;

  logic wr_any;
  logic wr_ctrl;
  logic wr_stat;
  logic wr_cmp_h;
  logic wr_cmp_l;

  cct_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  cct_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cnt_q(cnt), .wrap_evt(ovf_evt), .cnt_moved(cnt_moved)
  );

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .rise_sel(edge_q),
    .hit_rise(cap_rise), .hit_fall(cap_fall), .hit(cap_evt)
  );

  assign wr_any   = bus_sel && bus_wr;
  assign wr_ctrl  = wr_any && (bus_addr == RA_CTRL);
  assign wr_stat  = wr_any && (bus_addr == RA_STAT);
  assign wr_cmp_h = wr_any && (bus_addr == RA_CMP_H);
  assign wr_cmp_l = wr_any && (bus_addr == RA_CMP_L);

  assign cmp_hit = cnt_moved && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (wr_ctrl) edge_q <= bus_wdata[B_EDG];
  end

  always_comb begin
    ctrl.cap_ie    = 1'b0;
    ctrl.cmp_ie    = 1'b0;
    ctrl.ovf_ie    = 1'b0;
    ctrl.out_lvl   = 1'b0;
    ctrl.edge_rise = edge_q;
    ctrl.cap_ie    = ie_q[2];
    ctrl.cmp_ie    = ie_q[1];
    ctrl.ovf_ie    = ie_q[0];
    ctrl.out_lvl   = lvl_q;
  end

  logic [2:0] ie_q;
  logic       lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= '0;
      lvl_q <= 1'b0;
    end else if (wr_ctrl) begin
      ie_q  <= {bus_wdata[B_CAP], bus_wdata[B_CMP], bus_wdata[B_OVF]};
      lvl_q <= bus_wdata[B_LVL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags.cap <= cap_evt | (flags.cap & ~(wr_stat & bus_wdata[B_CAP]));
      flags.cmp <= cmp_hit | (flags.cmp & ~(wr_stat & bus_wdata[B_CMP]));
      flags.ovf <= ovf_evt | (flags.ovf & ~(wr_stat & bus_wdata[B_OVF]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (cap_evt) cap_q <= cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
    end else begin
      if (wr_cmp_h) cmp_q[CNT_W-1:BYTE_W] <= bus_wdata;
      if (wr_cmp_l) cmp_q[BYTE_W-1:0]     <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cmp_out <= 1'b0;
    else if (cmp_hit) cmp_out <= ctrl.out_lvl;
  end

  always_comb begin
    case (bus_addr)
      RA_CTRL:  bus_rdata = ctrl_to_byte(ctrl);
      RA_STAT:  bus_rdata = flags_to_byte(flags);
      RA_CNT_H: bus_rdata = pick_byte(cnt, 1'b1);
      RA_CNT_L: bus_rdata = pick_byte(cnt, 1'b0);
      RA_CAP_H: bus_rdata = pick_byte(cap_q, 1'b1);
      RA_CAP_L: bus_rdata = pick_byte(cap_q, 1'b0);
      RA_CMP_H: bus_rdata = pick_byte(cmp_q, 1'b1);
      default:  bus_rdata = pick_byte(cmp_q, 1'b0);
    endcase
  end

  assign irq = (flags.cap & ctrl.cap_ie) | (flags.cmp & ctrl.cmp_ie)
             | (flags.ovf & ctrl.ovf_ie);

  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt)) && flags.cap);
  a_r5_other_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_evt && !(wr_stat && bus_wdata[B_CAP])) |=> $stable(cap_q) && ($past(flags.cap) == flags.cap));
  a_r6_level: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_hit |=> (cmp_out == $past(ctrl.out_lvl)) && flags.cmp);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_hit |=> $stable(cmp_out));
  a_r3_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flags.ovf);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && bus_wdata[B_OVF] && !ovf_evt) |=> !flags.ovf);
endmodule

// File: tb/sim_cct_timer.sv
module sim_cct_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       cap_in = 1'b0;
  logic       cmp_out;
  logic       irq;

  int total = 0;
  int bad = 0;
  int unsigned k;

  always #10 clk = ~clk;

  cct_timer #(.PRESCALE(1), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k <= 0;
    else        k <= k + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rd16(input logic [2:0] ah, output logic [15:0] v);
    logic [7:0] h, l;
    rd(ah, h);
    rd(ah + 3'd1, l);
    v = {h, l};
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic until_k(input int unsigned t);
    while (k != t) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int unsigned k0, t;
    do_reset;
    rd(3'd0, b); chk("R2 ctrl after reset", b, 8'h00);
    rd(3'd1, b); chk("R2 status after reset", b, 8'h00);
    chk("R8 irq after reset", irq, 0);
    chk("R6 pin after reset", cmp_out, 0);
    rd16(3'd6, v); chk("R6 compare reset value", v, 16'hFFFF);

    wr(3'd0, 8'hFF); rd(3'd0, b); chk("R1 ctrl all ones", b, 8'hE3);
    wr(3'd0, 8'h1C); rd(3'd0, b); chk("R1 unused bits read zero", b, 8'h00);
    wr(3'd0, 8'hE3); rd(3'd0, b); chk("R1 ctrl readback", b, 8'hE3);
    do_reset;
    rd(3'd0, b); chk("R2 edge select kept through reset", b, 8'h02);

    // R3: counter sweep against the cycle count
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      rd16(3'd2, v); chk("R3 counter value", v, k[15:0]);
    end

    // R4: rising edge capture
    @(negedge clk); k0 = k; cap_in = 1'b1;
    until_k(k0 + 3);
    rd16(3'd4, v); chk("R4 captured count", v, (k0 + 2) & 16'hFFFF);
    rd(3'd1, b); chk("R4 capture flag", b, 8'h80);
    chk("R8 irq masked", irq, 0);
    wr(3'd0, 8'h82); #1 chk("R8 irq enabled capture", irq, 1);
    wr(3'd1, 8'h00); rd(3'd1, b); chk("R7 write zero keeps flag", b, 8'h80);
    wr(3'd1, 8'h80); rd(3'd1, b); chk("R7 write one clears", b, 8'h00);
    chk("R8 irq after clear", irq, 0);

    // R5: falling edge ignored while rising selected
    @(negedge clk); cap_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(3'd1, b); chk("R5 opposite edge no flag", b, 8'h00);
    rd16(3'd4, v); chk("R5 opposite edge keeps capture", v, (k0 + 2) & 16'hFFFF);

    // R5: falling edge selected
    wr(3'd0, 8'h80);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(3'd1, b); chk("R5 rising ignored when falling selected", b, 8'h00);
    k0 = k; cap_in = 1'b0;
    until_k(k0 + 3);
    rd16(3'd4, v); chk("R5 falling capture", v, (k0 + 2) & 16'hFFFF);
    chk("R8 irq falling capture", irq, 1);
    wr(3'd1, 8'hE0);

    // R6: compare drives high
    wr(3'd0, 8'h41);
    t = k + 40;
    wr(3'd6, t[15:8]); wr(3'd7, t[7:0]);
    until_k(t);
    chk("R6 pin before match", cmp_out, 0);
    rd(3'd1, b); chk("R6 no flag before match", b, 8'h00);
    until_k(t + 1);
    chk("R6 pin after match", cmp_out, 1);
    rd(3'd1, b); chk("R6 compare flag", b, 8'h40);
    chk("R8 irq compare", irq, 1);
    repeat (6) @(negedge clk);
    chk("R6 pin holds", cmp_out, 1);
    wr(3'd1, 8'h40);
    wr(3'd0, 8'h40);
    t = k + 40;
    wr(3'd6, t[15:8]); wr(3'd7, t[7:0]);
    until_k(t);
    chk("R6 pin before second match", cmp_out, 1);
    until_k(t + 1);
    chk("R6 pin driven low", cmp_out, 0);

    // R3: overflow
    wr(3'd1, 8'hE0);
    wr(3'd0, 8'h20);
    until_k(65535);
    rd16(3'd2, v); chk("R3 counter at top", v, 16'hFFFF);
    rd(3'd1, b); chk("R3 no overflow yet", b & 8'h20, 8'h00);
    until_k(65536);
    rd16(3'd2, v); chk("R3 counter wrapped", v, 16'h0000);
    rd(3'd1, b); chk("R3 overflow flag", b & 8'h20, 8'h20);
    chk("R8 irq overflow", irq, 1);
    wr(3'd1, 8'h20); rd(3'd1, b); chk("R7 overflow cleared", b & 8'h20, 8'h00);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule